// File: doc/BRIEF.md
# Environment-Config Permission Checker

This block decides whether a cache-block-management instruction may execute at the hart's current privilege level. For each request it reads the current privilege mode, a flag saying whether a guest is running under virtualization, and the enable setting taken from the machine, hypervisor and supervisor environment-configuration registers. It produces one of three verdicts: allow the instruction, raise an illegal-instruction exception, or raise a virtual-instruction fault.

The three configuration registers arrive as full-width vectors. A per-request kind input chooses which enable is tested in every register. Kind 0 tests the single zero-block enable bit. Kind 1 tests the multi-bit management-enable field. The verdict is taken from a fixed, ordered chain of checks, and the first check that fires decides the outcome. The verdict is registered and presented one cycle after the request as a one-hot triple with a valid strobe. The trap logic that acts on the verdict is outside this block.

Top module: `envcfg_perm_check`

## Requirements
- R1: While reset is held, and after release until the first request, `res_valid`, `res_allow`, `res_illegal` and `res_vfault` are all 0.
- R2: `res_valid` is 1 in the cycle after a cycle with `req_valid` = 1, and 0 in the cycle after a cycle with `req_valid` = 0. Back-to-back requests produce back-to-back results.
- R3: When `res_valid` is 1, exactly one of `res_allow`, `res_illegal` and `res_vfault` is 1. When `res_valid` is 0, all three are 0.
- R4: The privilege encoding is U=0, S=1, H=2, M=3, compared as unsigned values. A request at privilege 3 is always allowed, whatever the enables and the virtualization flag are.
- R5: A request below privilege 3 whose machine enable is clear gets illegal-instruction. This holds even when the virtualization fault conditions are also true.
- R6: With virtualization active, the machine enable set, privilege below 2 and the hypervisor enable clear, the verdict is virtual-instruction fault.
- R7: With virtualization active, the machine enable set, privilege 0 and the supervisor enable clear, the verdict is virtual-instruction fault, even when the hypervisor enable is set.
- R8: With virtualization inactive, the machine enable set, privilege 0 and the supervisor enable clear, the verdict is illegal-instruction. With virtualization inactive, the hypervisor enable has no effect on the verdict.
- R9: With `req_kind` = 0, each register's enable is its bit 7 (`ZERO_BIT`). With `req_kind` = 1, each register's enable is 1 when any bit of its field [5:4] (`MGMT_LSB`, `MGMT_W`) is set. Bits outside the selected enable have no effect.
- R10: A request that none of the checks in R5 to R8 denies is allowed. This includes privilege 2 with virtualization active and the hypervisor enable clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A check request is present this cycle |
| req_priv | input | 2 | Current privilege mode (U=0, S=1, H=2, M=3) |
| req_virt | input | 1 | Virtualization is active |
| req_kind | input | 1 | 0 tests the zero-block enable; 1 tests the management-enable field |
| cfg_mach | input | CFG_W | Machine environment-configuration register |
| cfg_hyp | input | CFG_W | Hypervisor environment-configuration register |
| cfg_sup | input | CFG_W | Supervisor environment-configuration register |
| res_valid | output | 1 | The verdict below is valid |
| res_allow | output | 1 | The instruction may execute |
| res_illegal | output | 1 | Raise illegal-instruction |
| res_vfault | output | 1 | Raise virtual-instruction fault |

## Verification
Two denials can be true in the same cycle. A clear machine enable can coincide with a virtualization fault condition, and a hypervisor denial can coincide with a supervisor denial. The bench provokes both on purpose. Directed requests clear several enables at once under active virtualization. Random requests with uniformly drawn privilege, flag and register values produce many more such overlaps. Each verdict is judged against a bench function that walks the ordered checks, so any overlap must resolve to the first check in the order.

// File: rtl/envcfg_chk_pkg.sv
package envcfg_chk_pkg;

   typedef enum logic [1:0] {
      PRIV_U = 2'd0,
      PRIV_S = 2'd1,
      PRIV_H = 2'd2,
      PRIV_M = 2'd3
   } priv_e;

   typedef enum logic [1:0] {
      VERD_ALLOW   = 2'd0,
      VERD_ILLEGAL = 2'd1,
      VERD_VFAULT  = 2'd2
   } verdict_e;

   typedef struct packed {
      logic m;
      logic h;
      logic s;
   } en_bits_t;

   localparam int unsigned NUM_LEVELS = 3;
   localparam int unsigned NUM_VERD   = 3;

endpackage

// File: rtl/envcfg_bit_pick.sv
module envcfg_bit_pick
   import envcfg_chk_pkg::*;
#(
   parameter int unsigned CFG_W    = 64,
   parameter int unsigned ZERO_BIT = 7,
   parameter int unsigned MGMT_LSB = 4,
   parameter int unsigned MGMT_W   = 2,
   parameter bit          MGMT_ANY = 1'b1
) (
   input  logic                          kind,
   input  logic [NUM_LEVELS*CFG_W-1:0]   cfg_flat,
   output en_bits_t                      en
);

   logic [NUM_LEVELS-1:0] picked;

   for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_level
      logic [CFG_W-1:0]  slice;
      logic [MGMT_W-1:0] field;
      logic              mg_en;
      logic              unused_rest;

      assign slice       = cfg_flat[i*CFG_W +: CFG_W];
      assign field       = slice[MGMT_LSB +: MGMT_W];
      assign unused_rest = ^slice;

      if (MGMT_ANY) begin : g_any
         assign mg_en = |field;
      end else begin : g_all
         assign mg_en = &field;
      end

      assign picked[i] = kind ? mg_en : slice[ZERO_BIT];
   end

   // Level 2 is the machine register, 1 the hypervisor, 0 the supervisor.
   assign en = '{m: picked[2], h: picked[1], s: picked[0]};

endmodule

// File: rtl/envcfg_decide.sv
module envcfg_decide
   import envcfg_chk_pkg::*;
(
   input  priv_e    priv,
   input  logic     virt,
   input  en_bits_t en,
   output verdict_e verd
);

   logic deny_mach;
   logic deny_virt;
   logic deny_sup;

   // The ordered chain: the first check that fires wins.
   assign deny_mach = (priv < PRIV_M) && !en.m;
   assign deny_virt = virt && (((priv < PRIV_H) && !en.h) ||
                               ((priv < PRIV_S) && !en.s));
   assign deny_sup  = (priv < PRIV_S) && !en.s;

   always_comb begin
      if (deny_mach)      verd = VERD_ILLEGAL;
      else if (deny_virt) verd = VERD_VFAULT;
      else if (deny_sup)  verd = VERD_ILLEGAL;
      else                verd = VERD_ALLOW;
   end

endmodule

// File: rtl/envcfg_out_reg.sv
module envcfg_out_reg
   import envcfg_chk_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     in_valid,
   input  verdict_e verd,
   output logic     res_valid,
   output logic     res_allow,
   output logic     res_illegal,
   output logic     res_vfault
);

   logic [NUM_VERD-1:0] hot_d;
   logic [NUM_VERD-1:0] hot_q;
   logic                valid_q;

   always_comb begin
      hot_d = '0;
      if (in_valid) begin
         unique case (verd)
            VERD_ILLEGAL: hot_d[1] = 1'b1;
            VERD_VFAULT:  hot_d[2] = 1'b1;
            default:      hot_d[0] = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         hot_q   <= '0;
      end else begin
         valid_q <= in_valid;
         hot_q   <= hot_d;
      end
   end

   assign res_valid   = valid_q;
   assign res_allow   = hot_q[0];
   assign res_illegal = hot_q[1];
   assign res_vfault  = hot_q[2];

   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> res_valid);
   a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !res_valid);
   a_r3_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> ($countones({res_allow, res_illegal, res_vfault}) == 1));
   a_r3_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> ({res_allow, res_illegal, res_vfault} == 3'b000));

endmodule

// File: rtl/envcfg_perm_check.sv
module envcfg_perm_check
   import envcfg_chk_pkg::*;
#(
   parameter int unsigned CFG_W    = 64,
   parameter int unsigned ZERO_BIT = 7,
   parameter int unsigned MGMT_LSB = 4,
   parameter int unsigned MGMT_W   = 2,
   parameter bit          MGMT_ANY = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [1:0]       req_priv,
   input  logic             req_virt,
   input  logic             req_kind,
   input  logic [CFG_W-1:0] cfg_mach,
   input  logic [CFG_W-1:0] cfg_hyp,
   input  logic [CFG_W-1:0] cfg_sup,
   output logic             res_valid,
   output logic             res_allow,
   output logic             res_illegal,
   output logic             res_vfault
);

   localparam int unsigned FLAT_W = NUM_LEVELS * CFG_W;

   initial begin
      a_cfg_zero_fits: assert (ZERO_BIT < CFG_W)
         else $error("ZERO_BIT outside register width");
      a_cfg_mgmt_fits: assert (MGMT_W >= 1 && MGMT_LSB + MGMT_W <= CFG_W)
         else $error("management field outside register width");
   end

   logic [FLAT_W-1:0] cfg_flat;
   en_bits_t          en;
   priv_e             priv;
   verdict_e          verd;

   assign cfg_flat = {cfg_mach, cfg_hyp, cfg_sup};
   assign priv     = priv_e'(req_priv);

   envcfg_bit_pick #(
      .CFG_W    (CFG_W),
      .ZERO_BIT (ZERO_BIT),
      .MGMT_LSB (MGMT_LSB),
      .MGMT_W   (MGMT_W),
      .MGMT_ANY (MGMT_ANY)
   ) u_pick (
      .kind     (req_kind),
      .cfg_flat (cfg_flat),
      .en       (en)
   );

   envcfg_decide u_decide (
      .priv (priv),
      .virt (req_virt),
      .en   (en),
      .verd (verd)
   );

   envcfg_out_reg u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (req_valid),
      .verd        (verd),
      .res_valid   (res_valid),
      .res_allow   (res_allow),
      .res_illegal (res_illegal),
      .res_vfault  (res_vfault)
   );

   a_r4_machine_allow: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_priv == 2'd3) |=> res_allow);
   a_r5_mach_deny_first: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_priv != 2'd3 && !en.m) |=> res_illegal);
   a_r6_hyp_vfault: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_virt && en.m && req_priv < 2'd2 && !en.h) |=> res_vfault);
   a_r7_sup_vfault: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_virt && en.m && req_priv == 2'd0 && !en.s) |=> res_vfault);
   a_r8_sup_illegal: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_virt && en.m && req_priv == 2'd0 && !en.s) |=> res_illegal);

endmodule

// File: tb/envcfg_perm_check_tb.sv
module envcfg_perm_check_tb;

   localparam int CW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_priv = 2'd0;
   logic          req_virt = 1'b0;
   logic          req_kind = 1'b0;
   logic [CW-1:0] cfg_mach = '0;
   logic [CW-1:0] cfg_hyp = '0;
   logic [CW-1:0] cfg_sup = '0;
   logic          res_valid, res_allow, res_illegal, res_vfault;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // Pending expectation from the previous drive.
   bit          pend_valid = 1'b0;
   logic [2:0]  pend_hot = 3'b000;
   string       pend_tag = "R2";

   always #5 clk = ~clk;

   envcfg_perm_check u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_priv(req_priv),
      .req_virt(req_virt), .req_kind(req_kind), .cfg_mach(cfg_mach),
      .cfg_hyp(cfg_hyp), .cfg_sup(cfg_sup), .res_valid(res_valid),
      .res_allow(res_allow), .res_illegal(res_illegal), .res_vfault(res_vfault)
   );

   // R9: kind 0 -> bit 7, kind 1 -> any bit of [5:4].
   function automatic bit en_of(input logic [CW-1:0] r, input bit kind);
      return kind ? (r[5] | r[4]) : r[7];
   endfunction

   // Returns {vfault, illegal, allow} and the deciding requirement tag.
   function automatic logic [2:0] expect_hot(input logic [1:0] p, input bit v,
         input bit kind, input logic [CW-1:0] m, input logic [CW-1:0] h,
         input logic [CW-1:0] s, output string tag);
      bit em, eh, es;
      em = en_of(m, kind); eh = en_of(h, kind); es = en_of(s, kind);
      if (p == 2'd3) begin tag = "R4"; return 3'b001; end
      if (!em) begin tag = "R5"; return 3'b010; end
      if (v && p < 2'd2 && !eh) begin tag = "R6"; return 3'b100; end
      if (v && p == 2'd0 && !es) begin tag = "R7"; return 3'b100; end
      if (p == 2'd0 && !es) begin tag = "R8"; return 3'b010; end
      tag = "R10";
      return 3'b001;
   endfunction

   task automatic check_out();
      logic [2:0] got;
      got = {res_vfault, res_illegal, res_allow};
      checks++;
      if (res_valid !== pend_valid) begin
         failures++;
         $display("FAIL R2 res_valid got %b exp %b", res_valid, pend_valid);
      end
      checks++;
      if (pend_valid && got !== pend_hot) begin
         failures++;
         $display("FAIL %s verdict {vf,ill,ok} got %b exp %b", pend_tag, got, pend_hot);
      end else if (!pend_valid && got !== 3'b000) begin
         failures++;
         $display("FAIL R3 idle verdict got %b exp 000", got);
      end
   endtask

   // Called just after a negedge: check the previous request, drive a new one.
   task automatic step(input bit v, input logic [1:0] p, input bit virt,
         input bit kind, input logic [CW-1:0] m, input logic [CW-1:0] h,
         input logic [CW-1:0] s);
      string t;
      @(negedge clk);
      check_out();
      req_valid = v; req_priv = p; req_virt = virt; req_kind = kind;
      cfg_mach = m; cfg_hyp = h; cfg_sup = s;
      pend_valid = v;
      pend_hot = expect_hot(p, virt, kind, m, h, s, t);
      pend_tag = t;
   endtask

   function automatic logic [CW-1:0] rnd64();
      return {$urandom(), $urandom()};
   endfunction

   localparam logic [CW-1:0] ZB = 64'h80;   // zero-block enable only
   localparam logic [CW-1:0] MB = 64'h10;   // management field only
   localparam logic [CW-1:0] ALL0 = 64'h0;

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'd20240611);
      // R1: outputs quiet during reset
      repeat (3) @(negedge clk);
      checks++;
      if ({res_valid, res_allow, res_illegal, res_vfault} !== 4'b0000) begin
         failures++;
         $display("FAIL R1 reset outputs got %b exp 0000",
                  {res_valid, res_allow, res_illegal, res_vfault});
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if ({res_valid, res_allow, res_illegal, res_vfault} !== 4'b0000) begin
         failures++;
         $display("FAIL R1 post-reset outputs got %b exp 0000",
                  {res_valid, res_allow, res_illegal, res_vfault});
      end

      // Directed corner cases
      step(1, 2'd3, 1, 0, ALL0, ALL0, ALL0);           // R4 machine always allowed
      step(1, 2'd1, 1, 0, ALL0, ALL0, ALL0);           // R5 outranks vfault
      step(1, 2'd0, 1, 0, ALL0, ZB, ALL0);             // R5 with only h set
      step(1, 2'd1, 1, 0, ZB, ALL0, ZB);               // R6 hyp denial
      step(1, 2'd0, 1, 0, ZB, ZB, ALL0);               // R7 sup denial under virt
      step(1, 2'd0, 0, 0, ZB, ALL0, ALL0);             // R8 illegal without virt
      step(1, 2'd1, 0, 0, ZB, ALL0, ALL0);             // R8 h ignored without virt -> allow
      step(1, 2'd2, 1, 0, ZB, ALL0, ALL0);             // R10 priv 2 passes
      step(1, 2'd0, 1, 0, MB, MB, MB);                 // R9 kind 0 ignores field -> R5
      step(1, 2'd0, 1, 1, MB, MB, MB);                 // R9 kind 1 uses field -> allow
      step(1, 2'd0, 1, 1, ZB, ZB, ZB);                 // R9 kind 1 ignores bit 7 -> R5
      step(1, 2'd0, 1, 1, 64'h20, 64'h30, 64'h0);      // R9 field any-bit, R7
      step(0, 2'd0, 0, 0, ALL0, ALL0, ALL0);           // R2 gap
      step(1, 2'd0, 0, 0, ~64'h0, ~64'h0, ~64'h0);     // R10 all set

      // Random mix with gaps and back-to-back requests
      for (int i = 0; i < 2000; i++) begin
         step(($urandom() % 4) != 0, 2'($urandom()), 1'($urandom()),
              1'($urandom()), rnd64(), rnd64(), rnd64());
      end
      step(0, 2'd0, 0, 0, ALL0, ALL0, ALL0);
      @(negedge clk);
      check_out();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule